// File: doc/BRIEF.md
# Burst Gate-Drive Sequencer with Boot Pulse

This block turns a burst-enable (interrupter) input and a digitized resonant-current feedback input into a complementary pair of gate-driver commands for a resonant power stage. When a burst opens, the sequencer issues a start-up pulse of programmable maximum length, counted in clock cycles, to kick the tank into oscillation. The first feedback transition ends that pulse early. From then on the drive is the burst window ANDed with feedback, so a dead feedback path can never produce a pulse that lasts the whole burst.

The two commands are never tri-stated or gated through driver enables. At idle the high-side command is low and the low-side command is high. Every change, including the first edge of a burst, swings both outputs at once. An overcurrent-ok input blocks the final stage combinationally and forces the idle levels. When the burst closes, the sequencer lets the current feedback half-cycle finish before it goes idle. It then holds a short minimum idle gap before it arms again. An optional halving of the boot length gives a quarter-cycle first pulse, which keeps the magnetising current centred.

Top module: `burst_gate_seq`

## Requirements
- R1: While reset is held and after reset with no burst, drv_hi is 0 and drv_lo is 1.
- R2: drv_lo is the logical inverse of drv_hi in every cycle.
- R3: With feedback held low, a burst produces exactly one drive pulse of boot_len clock cycles, after which drv_hi stays 0 for the rest of the burst.
- R4: A feedback transition (either direction) during the boot pulse ends it. From the following cycle drv_hi equals the synchronized feedback level while the burst lasts.
- R5: boot_len = 0 disables the boot pulse, and drv_hi follows synchronized feedback from the start of the burst.
- R6: With half_first = 1 the boot pulse lasts boot_len/2 cycles, rounded down, with a minimum of 1 when boot_len is nonzero.
- R7: oc_ok = 0 forces drv_hi = 0 and drv_lo = 1 in the same cycle, without waiting for a clock edge. Releasing it restores the sequenced drive at once.
- R8: After the burst enable drops, a drive pulse already high stays high until synchronized feedback goes low. After that the outputs stay idle, whatever feedback does.
- R9: A new burst starts only after at least two clock cycles in the idle state. A burst enable reasserted while the sequencer is still waiting for shutdown is served only after that idle gap.
- R10: Burst enable and feedback each pass through a two-flop synchronizer. A burst enable rising before a clock edge makes drv_hi rise after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_en | input | 1 | Burst window (interrupter), asynchronous |
| fb_in | input | 1 | Digitized resonant feedback, asynchronous |
| oc_ok | input | 1 | High when no overcurrent; low forces idle outputs |
| boot_len | input | 16 | Maximum boot pulse length in clock cycles; 0 disables |
| half_first | input | 1 | When high, the boot pulse uses half of boot_len |
| drv_hi | output | 1 | High-side gate-driver command |
| drv_lo | output | 1 | Low-side gate-driver command, complement of drv_hi |

## Verification
A wrong boot counter shows at the ports within one burst as a first pulse that is too long or too short, measured in whole cycles, with feedback held still. A sequencer state stuck in the run or shutdown phase shows up as drv_hi tracking feedback after the burst has closed. A lost feedback edge shows as the boot pulse running to its full length. A broken idle-gap counter shifts the rising edge of the next burst by at least one cycle. A cycle-level reference model running alongside random bursts, feedback toggling and overcurrent events catches any of these on the first cycle where the outputs differ.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BOOT = 2'd1,
    SQ_RUN  = 2'd2,
    SQ_STOP = 2'd3
  } seq_state_t;

  // Boot pulse length actually loaded into the timer.
  function automatic int unsigned boot_cycles(input int unsigned len, input bit half);
    int unsigned l;
    if (len == 0) begin
      l = 0;
    end else if (half) begin
      l = len >> 1;
      if (l == 0) l = 1;
    end else begin
      l = len;
    end
    return l;
  endfunction

endpackage

// File: rtl/bgs_sync.sv
module bgs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bgs_boot_timer.sv
module bgs_boot_timer #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             active,
  output logic             expire
);

  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (active && cnt != '0) begin
      cnt <= cnt - LEN_W'(1);
    end
  end

  // Last boot cycle: remaining count has reached one.
  assign expire = active && (cnt <= LEN_W'(1));

endmodule

// File: rtl/bgs_fsm.sv
module bgs_fsm
  import bgs_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int MIN_IDLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_s,
  input  logic             fb_s,
  input  logic             fb_edge,
  input  logic             boot_expire,
  input  logic [LEN_W-1:0] boot_load,
  output seq_state_t       state,
  output logic             start_evt
);

  localparam int IDLE_W = (MIN_IDLE < 2) ? 1 : $clog2(MIN_IDLE + 1);
  localparam logic [IDLE_W-1:0] ARM_AT = IDLE_W'((MIN_IDLE > 0) ? MIN_IDLE - 1 : 0);

  seq_state_t        nxt;
  logic [IDLE_W-1:0] idle_cnt;
  logic              armed;

  assign armed     = (idle_cnt >= ARM_AT);
  assign start_evt = (state == SQ_IDLE) && burst_s && armed;

  always_comb begin
    nxt = state;
    unique case (state)
      SQ_IDLE: if (start_evt) nxt = (boot_load == '0) ? SQ_RUN : SQ_BOOT;
      SQ_BOOT: if (fb_edge || boot_expire) nxt = burst_s ? SQ_RUN : SQ_STOP;
      SQ_RUN:  if (!burst_s) nxt = SQ_STOP;
      SQ_STOP: if (!fb_s) nxt = SQ_IDLE;
      default: nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      idle_cnt <= '0;
    end else begin
      state <= nxt;
      if (state != SQ_IDLE && nxt == SQ_IDLE) begin
        idle_cnt <= '0;
      end else if (state == SQ_IDLE && !armed) begin
        idle_cnt <= idle_cnt + IDLE_W'(1);
      end
    end
  end

endmodule

// File: rtl/bgs_out_stage.sv
module bgs_out_stage (
  input  logic act,
  input  logic oc_ok,
  output logic drv_hi,
  output logic drv_lo
);

  logic on;

  assign on     = act & oc_ok;
  assign drv_hi = on;
  assign drv_lo = ~on;

endmodule

// File: rtl/burst_gate_seq.sv
module burst_gate_seq
  import bgs_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_IDLE    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_en,
  input  logic             fb_in,
  input  logic             oc_ok,
  input  logic [LEN_W-1:0] boot_len,
  input  logic             half_first,
  output logic             drv_hi,
  output logic             drv_lo
);

  logic [1:0]       sync_q;
  logic             burst_s;
  logic             fb_s;
  logic             fb_q;
  logic             fb_edge;
  logic [LEN_W-1:0] boot_load_val;
  logic             boot_expire;
  logic             start_evt;
  seq_state_t       state;
  logic             boot_active;
  logic             run_active;
  logic             in_idle;
  logic             act;

  bgs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({fb_in, burst_en}),
    .q     (sync_q)
  );

  assign burst_s = sync_q[0];
  assign fb_s    = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= 1'b0;
    else        fb_q <= fb_s;
  end

  assign fb_edge       = fb_s ^ fb_q;
  assign boot_load_val = LEN_W'(boot_cycles(32'(boot_len), half_first));

  bgs_fsm #(.LEN_W(LEN_W), .MIN_IDLE(MIN_IDLE)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_s     (burst_s),
    .fb_s        (fb_s),
    .fb_edge     (fb_edge),
    .boot_expire (boot_expire),
    .boot_load   (boot_load_val),
    .state       (state),
    .start_evt   (start_evt)
  );

  assign boot_active = (state == SQ_BOOT);
  assign run_active  = (state == SQ_RUN) || (state == SQ_STOP);
  assign in_idle     = (state == SQ_IDLE);

  bgs_boot_timer #(.LEN_W(LEN_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_evt),
    .load_val (boot_load_val),
    .active   (boot_active),
    .expire   (boot_expire)
  );

  // Drive: boot pulse, otherwise burst window ANDed with feedback.
  assign act = boot_active | (run_active & fb_s);

  bgs_out_stage u_out (
    .act    (act),
    .oc_ok  (oc_ok),
    .drv_hi (drv_hi),
    .drv_lo (drv_lo)
  );

endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oc_ok,
  input logic             drv_hi,
  input logic             drv_lo,
  input logic             boot_active,
  input logic             run_active,
  input logic             in_idle,
  input logic             start_evt,
  input logic             fb_edge,
  input logic             fb_s,
  input logic [LEN_W-1:0] boot_load_val
);

  logic [LEN_W:0]   boot_run;
  logic [LEN_W-1:0] cap_len;
  logic [1:0]       idle_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_run <= '0;
      cap_len  <= '0;
      idle_run <= '0;
    end else begin
      boot_run <= boot_active ? boot_run + 1'b1 : '0;
      if (start_evt) cap_len <= boot_load_val;
      idle_run <= in_idle ? ((idle_run == 2'd3) ? idle_run : idle_run + 2'd1) : 2'd0;
    end
  end

  p_compl_r2: assert property (@(posedge clk) disable iff (!rst_n) drv_lo == !drv_hi);

  p_oc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n) !oc_ok |-> (!drv_hi && drv_lo));

  p_boot_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    boot_active |-> ({1'b0, cap_len} > boot_run));

  p_fb_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_active && fb_edge) |=> !boot_active);

  p_run_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && oc_ok) |-> (drv_hi == fb_s));

  p_zero_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && boot_load_val == '0) |=> !boot_active);

  p_idle_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> (idle_run >= 2'd1));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !drv_hi);

endmodule

bind burst_gate_seq bgs_checker #(.LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .oc_ok         (oc_ok),
  .drv_hi        (drv_hi),
  .drv_lo        (drv_lo),
  .boot_active   (boot_active),
  .run_active    (run_active),
  .in_idle       (in_idle),
  .start_evt     (start_evt),
  .fb_edge       (fb_edge),
  .fb_s          (fb_s),
  .boot_load_val (boot_load_val)
);

// File: tb/burst_gate_seq_test.sv
module burst_gate_seq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_en = 1'b0;
  logic        fb_in = 1'b0;
  logic        oc_ok = 1'b1;
  logic [15:0] boot_len = 16'd5;
  logic        half_first = 1'b0;
  logic        drv_hi;
  logic        drv_lo;

  int checks = 0;
  int fails  = 0;
  bit model_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_gate_seq uut (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .fb_in(fb_in), .oc_ok(oc_ok),
    .boot_len(boot_len), .half_first(half_first), .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  // ---------------- reference model (restated from the requirements) --------
  function automatic int exp_boot(input int len, input bit half);
    int v;
    v = half ? len / 2 : len;
    if (len != 0 && v < 1) v = 1;
    return v;
  endfunction

  logic mb1, mbs, mf1, mfs, mfq;
  int   mmode, midle, mrem;   // mode: 0 idle, 1 boot, 2 run, 3 waiting for shutdown

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb1 <= 0; mbs <= 0; mf1 <= 0; mfs <= 0; mfq <= 0;
      mmode <= 0; midle <= 0; mrem <= 0;
    end else begin
      mb1 <= burst_en; mbs <= mb1;
      mf1 <= fb_in; mfs <= mf1; mfq <= mfs;
      case (mmode)
        0: begin
          if (mbs && midle >= 1) begin
            mrem  <= exp_boot(int'(boot_len), half_first);
            mmode <= (exp_boot(int'(boot_len), half_first) == 0) ? 2 : 1;
          end else if (midle < 1) midle <= midle + 1;
        end
        1: begin
          if (mfs != mfq || mrem <= 1) mmode <= mbs ? 2 : 3;
          else mrem <= mrem - 1;
        end
        2: if (!mbs) mmode <= 3;
        default: if (!mfs) begin mmode <= 0; midle <= 0; end
      endcase
    end
  end

  function automatic bit model_hi();
    return oc_ok && (mmode == 1 || (mmode >= 2 && mfs));
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk_hi(input bit exp, input string req);
    check(drv_hi === exp && drv_lo === !exp, req, int'(drv_hi), int'(exp));
  endtask

  task automatic count_hi(input int n, output int c);
    c = int'(drv_hi);
    repeat (n) begin
      step();
      c += int'(drv_hi);
    end
  endtask

  task automatic settle();
    burst_en = 0; fb_in = 0; oc_ok = 1;
    step(60);
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      check(drv_lo === !drv_hi, "R2 complement", int'(drv_lo), int'(!drv_hi));
      check(drv_hi === model_hi(), "R4 model drive", int'(drv_hi), int'(model_hi()));
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c;
    void'($urandom(32'd20240611));
    @(negedge clk);
    chk_hi(1'b0, "R1 in reset");
    step(3);
    rst_n = 1;
    step(4);
    chk_hi(1'b0, "R1 after reset");

    // R10 latency and R3 full boot length with dead feedback
    boot_len = 16'd5; half_first = 0;
    burst_en = 1;
    step(2);
    chk_hi(1'b0, "R10 before third edge");
    step(1);
    chk_hi(1'b1, "R10 after third edge");
    count_hi(30, c);
    check(c == 5, "R3 boot length dead feedback", c, 5);
    settle();

    // R6 halved boot
    half_first = 1;
    burst_en = 1;
    step(3);
    count_hi(20, c);
    check(c == 2, "R6 half of 5", c, 2);
    settle();
    boot_len = 16'd1;
    burst_en = 1;
    step(3);
    count_hi(20, c);
    check(c == 1, "R6 half of 1", c, 1);
    settle();
    half_first = 0;

    // R5 zero length
    boot_len = 16'd0;
    burst_en = 1;
    step(3);
    count_hi(10, c);
    check(c == 0, "R5 no boot pulse", c, 0);
    fb_in = 1;
    step(1);
    chk_hi(1'b0, "R5 feedback not yet synced");
    step(1);
    chk_hi(1'b1, "R5 follows feedback");
    settle();

    // R4 feedback cuts boot pulse
    boot_len = 16'd40;
    burst_en = 1;
    step(3);
    chk_hi(1'b1, "R4 boot running");
    step(5);
    fb_in = 1;
    step(3);
    chk_hi(1'b1, "R4 high across handover");
    fb_in = 0;
    step(1);
    chk_hi(1'b1, "R4 fall not yet synced");
    step(1);
    chk_hi(1'b0, "R4 boot cut, follows feedback");
    count_hi(10, c);
    check(c == 0, "R4 stays low with feedback low", c, 0);

    // R8 shutdown waits for the feedback half-cycle
    fb_in = 1;
    step(2);
    chk_hi(1'b1, "R8 running high");
    burst_en = 0;
    step(5);
    chk_hi(1'b1, "R8 pulse not cut at burst drop");
    fb_in = 0;
    step(1);
    chk_hi(1'b1, "R8 still high before sync");
    step(1);
    chk_hi(1'b0, "R8 idle after feedback fall");
    fb_in = 1;
    count_hi(4, c);
    check(c == 0, "R8 no pulse after shutdown", c, 0);
    settle();

    // R9 reassert while waiting for shutdown
    boot_len = 16'd3;
    burst_en = 1;
    step(8);
    fb_in = 1;
    step(2);
    burst_en = 0;
    step(4);
    burst_en = 1;
    step(4);
    chk_hi(1'b1, "R9 still in shutdown wait");
    fb_in = 0;
    step(1); chk_hi(1'b1, "R9 step1");
    step(1); chk_hi(1'b0, "R9 step2 idle level");
    step(1); chk_hi(1'b0, "R9 idle gap first");
    step(1); chk_hi(1'b0, "R9 idle gap second");
    step(1); chk_hi(1'b1, "R9 new boot after gap");
    settle();

    // R7 overcurrent blocks combinationally
    boot_len = 16'd40;
    burst_en = 1;
    step(3);
    chk_hi(1'b1, "R7 boot running");
    oc_ok = 0;
    #1;
    chk_hi(1'b0, "R7 forced idle without clock");
    oc_ok = 1;
    #1;
    chk_hi(1'b1, "R7 released");
    settle();

    // random phase against the model
    model_on = 1;
    for (int i = 0; i < 6000; i++) begin
      step(1);
      if ($urandom % 40 == 0) burst_en = ~burst_en;
      if ($urandom % 4 == 0) fb_in = ~fb_in;
      oc_ok = ($urandom % 50) != 0;
      if ($urandom % 100 == 0) boot_len = 16'($urandom % 10);
      if ($urandom % 150 == 0) half_first = ~half_first;
    end
    model_on = 0;

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule